// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Interface Port

This block is a byte-at-a-time SPI unit that sits on a small processor's register bus. Software sets the operating mode in a control byte, loads a byte into the data register and then polls a status flag or waits for an interrupt. In master mode, loading the data register starts a serial clock generated from the system clock. Eight bits are sent on MOSI while eight bits are taken in from MISO. The clock then halts at its idle level and the completion flag rises. Reading the data register returns the byte that was received.

In slave mode, the serial clock and MOSI come from an external master. The block takes part only while its active-low select input is low. While the select input is high, it ignores clock edges and releases MISO. Clock polarity, clock phase, bit order and one of four clock rates are all set in the control byte. The interrupt output needs the completion flag plus two enables: a local bit and a system-level input.

Top module: `spi_port`

## Requirements
- R1: After reset, the control and status registers read 0, irq is 0, and neither sck_oe nor miso_oe is asserted. Control bits, from 7 down to 0, are: interrupt enable, port enable, LSB-first, master, clock polarity, clock phase, rate[1:0].
- R2: In master mode with the port enabled, a write to the data register starts a transfer. The transfer sends the written byte on mosi_o, captures 8 bits from miso_i, and after completion the data register reads the captured byte.
- R3: A master transfer makes exactly 16 SCK edges. The clock then stays still, and status bit 7 (completion flag) becomes 1.
- R4: irq is 1 exactly when the completion flag, control bit 7 and sys_irq_en are all 1.
- R5: The LSB-first bit selects the wire order: 0 sends and receives the most significant bit first, 1 the least significant bit first.
- R6: SCK idles high when the polarity bit is 1 and low when it is 0.
- R7: With phase 0, data is sampled on the leading SCK edge and changed on the trailing edge. With phase 1, data is sampled on the trailing edge and changed on the leading edge.
- R8: In master mode, each SCK half period lasts 2, 8, 32 or 64 system clocks for rate codes 0, 1, 2 and 3.
- R9: In slave mode, the block shifts only while ss_n is low and drives miso_oe only then. With ss_n high, SCK edges change neither the flag nor the data register.
- R10: While the port enable bit is 0, a data write starts no transfer, sck_oe and mosi_oe stay 0, and the flag stays clear.
- R11: Writing 0 to status bit 7 clears the flag, and writing 0 to status bit 6 clears the collision bit. A data write during a transfer is ignored and sets status bit 6.
- R12: Register addresses: 0 is control (read/write), 1 is data (write loads transmit, read returns the shift register), 2 is status {flag, collision, 6'b0}, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sys_irq_en | input | 1 | System-level interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_o |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | Output enable for miso_o |
| ss_n | input | 1 | Active-low slave select |

## Verification
The embedded properties are checked on every cycle. They cover these points: the flag rises only after a completed byte, ticks are never back to back, SCK returns to its idle level when the clock stops, irq stays low without the system enable, a busy write always raises the collision bit, and clearing the enable stops any transfer. The bench scenarios alone show the bit-level behaviour. That includes the wire bit order, which edge samples and which edge changes data under each phase and polarity, the exact half-period per rate code, and that bytes are exchanged correctly in both master and slave roles. A deselected slave is also checked to keep its data under clock activity.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int BYTE_W   = 8;
  localparam int EDGES    = 2 * BYTE_W;
  localparam int MAX_HALF = 64;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_DATA   = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;

  // control byte, first field is bit 7
  typedef struct packed {
    logic       irq_en;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // system clocks per SCK half period for a rate code
  function automatic int unsigned half_period(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

  // bit presented on the wire for a given order
  function automatic logic wire_bit(input logic [BYTE_W-1:0] v, input logic lsb_first);
    return lsb_first ? v[0] : v[BYTE_W-1];
  endfunction

  // advance the shift register by one bit
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] v,
                                                 input logic b, input logic lsb_first);
    return lsb_first ? {b, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], b};
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int HALF_MAX = MAX_HALF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  logic [1:0] rate,
  input  logic       cpol,
  output logic       tick,
  output logic       sck,
  output logic       run
);
  localparam int CNT_W = $clog2(HALF_MAX);

  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic [CNT_W-1:0] reload;

  assign reload = CNT_W'(half_period(rate) - 1);
  assign tick   = run && (cnt == '0);
  assign sck    = cpol ^ phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      phase <= 1'b0;
    end else if (stop) begin
      run   <= 1'b0;
      phase <= 1'b0;
    end else if (start) begin
      run   <= 1'b1;
      cnt   <= reload;
      phase <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        cnt   <= reload;
        phase <= ~phase;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R8: the shortest half period is two clocks, so ticks never touch
  a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6: once the clock halts, SCK sits at the idle level
  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (sck == cpol));

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic mosi_pin,
  input  logic ss_n_pin,
  output logic edge_ev,
  output logic mosi_s,
  output logic ss_act
);
  logic [SYNC_STAGES:0]   sck_q;
  logic [SYNC_STAGES-1:0] mosi_q;
  logic [SYNC_STAGES-1:0] ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      ss_q   <= '1;
    end else begin
      sck_q  <= {sck_q[SYNC_STAGES-1:0], sck_pin};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_pin};
      ss_q   <= {ss_q[SYNC_STAGES-2:0], ss_n_pin};
    end
  end

  assign edge_ev = sck_q[SYNC_STAGES] ^ sck_q[SYNC_STAGES-1];
  assign mosi_s  = mosi_q[SYNC_STAGES-1];
  assign ss_act  = ~ss_q[SYNC_STAGES-1];

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic              abort,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              pin_in,
  output logic              out_bit,
  output logic [BYTE_W-1:0] sr,
  output logic              busy,
  output logic              done
);
  localparam int CW = $clog2(EDGES);

  logic [CW-1:0] cnt;
  logic          in_bit;
  logic          lead, last, sample_ev, shift_ev, feed;

  assign lead      = ~cnt[0];
  assign last      = ev && (cnt == CW'(EDGES - 1));
  assign sample_ev = ev && !abort && (cpha ? !lead : lead);
  assign shift_ev  = ev && !abort && (cpha ? ((lead && cnt != '0) || last) : !lead);
  assign feed      = (cpha && last) ? pin_in : in_bit;
  assign done      = last && !abort;
  assign busy      = (cnt != '0);
  assign out_bit   = wire_bit(sr, lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (abort) begin
      cnt <= '0;
    end else if (ev) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_bit <= 1'b0;
      sr     <= '0;
    end else begin
      if (sample_ev) in_bit <= pin_in;
      if (load)          sr <= load_val;
      else if (shift_ev) sr <= shift_in(sr, feed, lsb_first);
    end
  end

  // R10: an abort always returns the engine to idle
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sys_irq_en,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n
);
  ctrl_t             ctrl;
  logic              flag, wcol;
  logic              wr_ctrl, wr_data, wr_stat;
  logic              busy, load_ok, clash, m_start, m_stop;
  logic              m_tick, m_sck, m_run;
  logic              s_edge, s_mosi, ss_act;
  logic              ev, abort, pin_in, xfer_done, eng_busy, out_bit;
  logic [BYTE_W-1:0] sr;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_stat = bus_wr && (bus_addr == A_STATUS);

  assign busy    = ctrl.master ? m_run : eng_busy;
  assign load_ok = wr_data && !busy;
  assign clash   = wr_data && busy;
  assign m_start = load_ok && ctrl.en && ctrl.master;
  assign m_stop  = xfer_done || !ctrl.en || !ctrl.master;

  assign ev     = ctrl.master ? m_tick : (s_edge && ss_act && ctrl.en);
  assign abort  = !ctrl.en || (!ctrl.master && !ss_act);
  assign pin_in = ctrl.master ? miso_i : s_mosi;

  spi_rate_gen u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .start (m_start),
    .stop  (m_stop),
    .rate  (ctrl.rate),
    .cpol  (ctrl.cpol),
    .tick  (m_tick),
    .sck   (m_sck),
    .run   (m_run)
  );

  spi_slave_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_pin  (sck_i),
    .mosi_pin (mosi_i),
    .ss_n_pin (ss_n),
    .edge_ev  (s_edge),
    .mosi_s   (s_mosi),
    .ss_act   (ss_act)
  );

  spi_bit_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .abort     (abort),
    .cpha      (ctrl.cpha),
    .lsb_first (ctrl.lsb_first),
    .load      (load_ok),
    .load_val  (bus_wdata),
    .pin_in    (pin_in),
    .out_bit   (out_bit),
    .sr        (sr),
    .busy      (eng_busy),
    .done      (xfer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      flag <= 1'b0;
      wcol <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
      if (xfer_done)    flag <= 1'b1;
      else if (wr_stat) flag <= flag & bus_wdata[7];
      if (clash)        wcol <= 1'b1;
      else if (wr_stat) wcol <= wcol & bus_wdata[6];
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = ctrl;
      A_DATA:   bus_rdata = sr;
      A_STATUS: bus_rdata = {flag, wcol, 6'b0};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq     = flag & ctrl.irq_en & sys_irq_en;
  assign sck_o   = m_sck;
  assign sck_oe  = ctrl.en & ctrl.master;
  assign mosi_o  = out_bit;
  assign mosi_oe = ctrl.en & ctrl.master;
  assign miso_o  = out_bit;
  assign miso_oe = ctrl.en & ~ctrl.master & ~ss_n;

  // R3: the flag only rises from a finished byte
  a_r3_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(xfer_done));

  // R4: no request without the system-level enable
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_irq_en |-> !irq);

  // R11: a data write during a transfer marks a collision
  a_r11_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol);

  // R10: dropping the enable halts the master clock
  a_r10_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> !m_run);

endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sys_irq_en = 1'b0;
  logic       irq;
  logic       sck_i = 1'b0, sck_o, sck_oe;
  logic       mosi_i = 1'b0, mosi_o, mosi_oe;
  logic       miso_i = 1'b0, miso_o, miso_oe;
  logic       ss_n = 1'b1;

  spi_port dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench slave model state
  bit         mon_on = 0;
  bit         cur_cpol, cur_cpha, cur_dord;
  logic [7:0] sbyte, got;
  int         scnt, edges, cyc, last_cyc, meas_half;
  logic       mosi_prev;
  logic [7:0] exp_q[$];

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_flag(input int limit);
    logic [7:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(2'd2, s);
      if (s[7]) break;
    end
  endtask

  function automatic logic pick(input logic [7:0] v, input int i, input bit lsb);
    return lsb ? v[i] : v[7-i];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) mosi_prev <= mosi_o;

  // monitor: acts as the remote slave and scores each byte seen on MOSI
  always @(sck_o) begin
    if (mon_on) begin
      bit lead;
      lead = (sck_o != cur_cpol);
      if (edges > 0) meas_half = cyc - last_cyc;
      last_cyc = cyc;
      edges++;
      if (cur_cpha ? !lead : lead) begin
        got = cur_dord ? {mosi_prev, got[7:1]} : {got[6:0], mosi_prev};
        scnt++;
        if (scnt < 8) miso_i = pick(sbyte, scnt, cur_dord);
        else begin
          if (exp_q.size() == 0) check("R2 mosi byte without expectation", 1, 0);
          else check("R2/R5/R7 byte seen on mosi", got, exp_q.pop_front());
        end
      end
    end
  end

  // master-mode driver: pushes the expected wire byte, runs the transfer
  task automatic m_xfer(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] rx,
                        input bit collide, input bit irq_test);
    logic [7:0] d;
    wr(2'd0, c);
    cur_cpol = c[3]; cur_cpha = c[2]; cur_dord = c[5];
    sbyte = rx; scnt = 0; edges = 0; got = '0;
    miso_i = pick(rx, 0, c[5]);
    exp_q.push_back(tx);
    mon_on = 1;
    wr(2'd1, tx);
    if (collide) begin
      repeat (20) @(negedge clk);
      wr(2'd1, 8'hFF);
    end
    wait_flag(4000);
    repeat (20) @(negedge clk);
    check("R3 sck edge count", edges, 16);
    check("R6 sck idle level", sck_o, c[3]);
    check("R8 half period", meas_half, (c[1:0] == 0) ? 2 : (c[1:0] == 1) ? 8 : (c[1:0] == 2) ? 32 : 64);
    rd(2'd2, d);
    check("R3 completion flag", d[7], 1);
    check("R11 collision bit", d[6], collide);
    rd(2'd1, d);
    check("R2 received byte", d, rx);
    mon_on = 0;
    if (irq_test) begin
      sys_irq_en = 1'b1; #1;
      check("R4 irq with all enables", irq, 1);
      sys_irq_en = 1'b0; #1;
      check("R4 irq without system enable", irq, 0);
      sys_irq_en = 1'b1;
      wr(2'd0, c & 8'h7F); #1;
      check("R4 irq without local enable", irq, 0);
      sys_irq_en = 1'b0;
    end
    wr(2'd2, 8'h00);
    rd(2'd2, d);
    check("R11 status cleared", d, 0);
  endtask

  // slave-mode driver: the bench plays the external master
  task automatic s_xfer(input logic [7:0] c, input logic [7:0] mtx, input logic [7:0] stx);
    logic [7:0] d, seen;
    bit pol, lsb;
    pol = c[3]; lsb = c[5]; seen = '0;
    wr(2'd0, c);
    wr(2'd1, stx);
    sck_i = pol;
    repeat (8) @(negedge clk);
    ss_n = 1'b0;
    mosi_i = pick(mtx, 0, lsb);
    repeat (8) @(negedge clk);
    check("R9 miso driven while selected", miso_oe, 1);
    for (int k = 0; k < 8; k++) begin
      if (!c[2]) begin
        seen = lsb ? {miso_o, seen[7:1]} : {seen[6:0], miso_o};
        sck_i = ~pol;
        repeat (8) @(negedge clk);
        sck_i = pol;
        if (k < 7) mosi_i = pick(mtx, k + 1, lsb);
        repeat (8) @(negedge clk);
      end else begin
        sck_i = ~pol;
        mosi_i = pick(mtx, k, lsb);
        repeat (8) @(negedge clk);
        seen = lsb ? {miso_o, seen[7:1]} : {seen[6:0], miso_o};
        sck_i = pol;
        repeat (8) @(negedge clk);
      end
    end
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 miso released when deselected", miso_oe, 0);
    check("R5/R7 slave byte on miso", seen, stx);
    rd(2'd2, d);
    check("R9 slave completion flag", d[7], 1);
    rd(2'd1, d);
    check("R9 slave received byte", d, mtx);
    wr(2'd2, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] d;
    cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, d); check("R1 control after reset", d, 0);
    rd(2'd2, d); check("R1 status after reset", d, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 sck_oe after reset", sck_oe, 0);
    check("R1 miso_oe after reset", miso_oe, 0);

    wr(2'd0, 8'h2D); rd(2'd0, d); check("R12 control read back", d, 8'h2D);
    rd(2'd3, d); check("R12 unused address", d, 0);
    wr(2'd0, 8'h00);

    m_xfer(8'h50, 8'hA5, 8'h3C, 0, 0);          // msb first, mode 0, fastest
    m_xfer(8'h75, 8'h1E, 8'hC7, 0, 0);          // lsb first, phase 1, rate 1
    m_xfer(8'hDB, 8'h6B, 8'h92, 0, 1);          // idle high, phase 0, rate 3, irq
    m_xfer(8'h7E, 8'hF0, 8'h0F, 1, 0);          // idle high, phase 1, lsb, rate 2, collision
    check("R2 scoreboard drained", exp_q.size(), 0);

    s_xfer(8'h40, 8'h5A, 8'hC3);
    s_xfer(8'h6C, 8'h81, 8'h7E);

    // R9: deselected slave ignores clock activity
    wr(2'd0, 8'h40);
    wr(2'd1, 8'h3C);
    ss_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      sck_i = ~sck_i; mosi_i = ~mosi_i;
      repeat (6) @(negedge clk);
    end
    check("R9 miso_oe while deselected", miso_oe, 0);
    rd(2'd2, d); check("R9 flag while deselected", d, 0);
    rd(2'd1, d); check("R9 data kept while deselected", d, 8'h3C);

    // R10: disabled port makes no transfer
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h11);
    repeat (100) @(negedge clk);
    check("R10 sck_oe while disabled", sck_oe, 0);
    check("R10 mosi_oe while disabled", mosi_oe, 0);
    rd(2'd2, d); check("R10 no flag while disabled", d, 0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule